// File: doc/BRIEF.md
# Multi-Channel Reloading Timer Unit

This block holds three interval timers and one wide free-running counter behind a simple register interface of write strobe, word address and data. Two of the interval timers are 16 bits wide and the third is 32 bits wide. Each counts down on a selected clock-enable strobe. When it passes zero it either reloads from its programmed load value (periodic mode) or wraps to all ones (free mode). In both modes it latches a pending interrupt that stays on its `irq` line until software writes that timer's clear register.

The wide counter is 40 bits and counts up on the fast tick strobe. It never interrupts. Software samples its low word and takes differences modulo 2^32 to measure elapsed time, so the low word rolls over cleanly into the high byte. Both tick strobes come from outside as one-cycle clock enables. The block does not divide the system clock itself.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every load, value and control register reads zero, the wide counter reads zero and is stopped, and `irq` is all zero.
- R2: A write to a stopped timer's load register (word 4t+0 for timer t = 0..2) also sets its count. Timers 0 and 1 keep the low 16 bits and timer 2 keeps all 32. Reading the value register (word 4t+1) returns the live count zero-extended to 32 bits.
- R3: In periodic mode with load value N-1, an enabled timer decrements once per selected tick. On the tick that finds it at zero, it reloads N-1 and sets its `irq` bit, which is visible the cycle after that tick, giving one interrupt every N ticks.
- R4: With the periodic bit clear, the tick that finds the count at zero wraps it to all ones of the timer's width (0xFFFF or 0xFFFFFFFF) and sets its `irq` bit.
- R5: Control bit 3 set makes the timer count on `slowTick`. Clear makes it count on `fastTick`. The other strobe has no effect on the count.
- R6: Any write to a timer's clear register (word 4t+3) drops its `irq` bit on the next cycle. If an underflow of that timer happens in the same cycle, the interrupt stays set.
- R7: With control bit 7 clear the count is frozen against both ticks, and a pending `irq` bit is kept.
- R8: A load write while the timer runs leaves the current count unchanged. The new value is used at the next reload.
- R9: The control register (word 4t+2) stores only bit 7 (run), bit 6 (periodic) and bit 3 (slow tick) and reads back with all other bits zero.
- R10: Word 13 holds the wide counter's run flag in bit 8 and its bits 39:32 in bits 7:0. When the run flag is set the counter increments by one per `fastTick` and ignores `slowTick`. When the flag is clear it holds.
- R11: A write to word 12 sets wide counter bits 31:0, and a write to word 13 sets bits 39:32 from data bits 7:0. The low word wraps modulo 2^32 and carries into bits 39:32.
- R12: Reads of unmapped words (14, 15) and of clear registers return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowTick | input | 1 | Slow clock-enable strobe, one cycle wide |
| fastTick | input | 1 | Fast clock-enable strobe, one cycle wide |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Word address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 3 | Pending interrupt per interval timer |

## Verification
The assertions assume that each interrupt rise follows a cycle carrying a tick strobe, and that a clear write in a cycle without any tick always drops the interrupt. A stopped timer's count is assumed to move only through its load register. The wide counter is assumed to change only on a fast tick or a write to its own words. The stimulus drives tick strobes one cycle at a time under explicit control, so every count, reload and wrap lands on a predictable edge. Only one planned collision is driven: a clear write in the same cycle as an underflow. The bench lets the clear-drops property stand aside there because a tick is present.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int NUM_TMR = 3;

  localparam int CTL_RUN = 7;
  localparam int CTL_PER = 6;
  localparam int CTL_SLOW = 3;
  localparam int WIDE_RUN_BIT = 8;

  localparam logic [1:0] REG_LOAD = 2'd0;
  localparam logic [1:0] REG_VAL = 2'd1;
  localparam logic [1:0] REG_CTL = 2'd2;
  localparam logic [1:0] REG_CLR = 2'd3;
  localparam logic [1:0] REG_WLO = 2'd0;
  localparam logic [1:0] REG_WHI = 2'd1;
  localparam logic [1:0] WIDE_SLOT = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_TMR-1:0] loadWr;
    logic [NUM_TMR-1:0] clrWr;
    logic wideLoWr;
    logic wideHiWr;
    logic [DATA_W-1:0] data;
  } strobe_t;

  function automatic logic [DATA_W-1:0] widthMask(input int w);
    logic [63:0] m;
    m = (64'd1 << w) - 64'd1;
    return m[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NARROW_CNT = 2,
  parameter int NARROW_W = 16,
  parameter int BROAD_W = 32,
  parameter int FREE_W = 40
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_TMR-1:0][DATA_W-1:0] cntOut,
  input  logic [FREE_W-1:0] wideCnt,
  output strobe_t strb,
  output logic [NUM_TMR-1:0] tmrEn,
  output logic [NUM_TMR-1:0] tmrPer,
  output logic [NUM_TMR-1:0] tmrSlow,
  output logic [NUM_TMR-1:0][DATA_W-1:0] loadVal,
  output logic wideEn,
  output logic [DATA_W-1:0] rdData
);
  localparam int HI_W = FREE_W - DATA_W;

  logic [1:0] slot;
  logic [1:0] sel;
  logic [NUM_TMR-1:0] ctlWr;

  assign slot = addr[3:2];
  assign sel = addr[1:0];

  genvar g;
  generate
    for (g = 0; g < NUM_TMR; g++) begin : g_dec
      assign strb.loadWr[g] = wrEn && (slot == 2'(g)) && (sel == REG_LOAD);
      assign strb.clrWr[g] = wrEn && (slot == 2'(g)) && (sel == REG_CLR);
      assign ctlWr[g] = wrEn && (slot == 2'(g)) && (sel == REG_CTL);
    end
  endgenerate

  assign strb.wideLoWr = wrEn && (slot == WIDE_SLOT) && (sel == REG_WLO);
  assign strb.wideHiWr = wrEn && (slot == WIDE_SLOT) && (sel == REG_WHI);
  assign strb.data = wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrEn <= '0;
      tmrPer <= '0;
      tmrSlow <= '0;
      loadVal <= '0;
      wideEn <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_TMR; i++) begin
        if (strb.loadWr[i])
          loadVal[i] <= wrData & widthMask((i < NARROW_CNT) ? NARROW_W : BROAD_W);
        if (ctlWr[i]) begin
          tmrEn[i] <= wrData[CTL_RUN];
          tmrPer[i] <= wrData[CTL_PER];
          tmrSlow[i] <= wrData[CTL_SLOW];
        end
      end
      if (strb.wideHiWr) wideEn <= wrData[WIDE_RUN_BIT];
    end
  end

  always_comb begin
    rdData = '0;
    if (slot < 2'(NUM_TMR)) begin
      case (sel)
        REG_LOAD: rdData = loadVal[slot];
        REG_VAL:  rdData = cntOut[slot];
        REG_CTL: begin
          rdData[CTL_RUN] = tmrEn[slot];
          rdData[CTL_PER] = tmrPer[slot];
          rdData[CTL_SLOW] = tmrSlow[slot];
        end
        default: rdData = '0;
      endcase
    end else if (slot == WIDE_SLOT) begin
      if (sel == REG_WLO) rdData = wideCnt[DATA_W-1:0];
      else if (sel == REG_WHI) begin
        rdData[HI_W-1:0] = wideCnt[FREE_W-1:DATA_W];
        rdData[WIDE_RUN_BIT] = wideEn;
      end
    end
  end
endmodule

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
#(
  parameter int NARROW_CNT = 2,
  parameter int NARROW_W = 16,
  parameter int BROAD_W = 32,
  parameter int FREE_W = 40
) (
  input  logic clk,
  input  logic rstN,
  input  logic slowTick,
  input  logic fastTick,
  input  strobe_t strb,
  input  logic [NUM_TMR-1:0] tmrEn,
  input  logic [NUM_TMR-1:0] tmrPer,
  input  logic [NUM_TMR-1:0] tmrSlow,
  input  logic [NUM_TMR-1:0][DATA_W-1:0] loadVal,
  input  logic wideEn,
  output logic [NUM_TMR-1:0][DATA_W-1:0] cntOut,
  output logic [NUM_TMR-1:0] irq,
  output logic [FREE_W-1:0] wideCnt
);
  localparam int HI_W = FREE_W - DATA_W;

  logic [NUM_TMR-1:0] tickSel;
  logic [NUM_TMR-1:0][DATA_W-1:0] cntQ;
  logic [NUM_TMR-1:0] pendQ;
  logic [FREE_W-1:0] wideQ;

  genvar g;
  generate
    for (g = 0; g < NUM_TMR; g++) begin : g_tick
      assign tickSel[g] = tmrSlow[g] ? slowTick : fastTick;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      pendQ <= '0;
    end else begin
      for (int i = 0; i < NUM_TMR; i++) begin
        if (strb.loadWr[i] && !tmrEn[i]) begin
          cntQ[i] <= strb.data & widthMask((i < NARROW_CNT) ? NARROW_W : BROAD_W);
        end else if (tmrEn[i] && tickSel[i]) begin
          if (cntQ[i] == '0)
            cntQ[i] <= tmrPer[i] ? loadVal[i]
                                 : widthMask((i < NARROW_CNT) ? NARROW_W : BROAD_W);
          else
            cntQ[i] <= cntQ[i] - DATA_W'(1);
        end
        if (tmrEn[i] && tickSel[i] && (cntQ[i] == '0)) pendQ[i] <= 1'b1;
        else if (strb.clrWr[i]) pendQ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wideQ <= '0;
    end else if (strb.wideLoWr) begin
      wideQ[DATA_W-1:0] <= strb.data;
    end else if (strb.wideHiWr) begin
      wideQ[FREE_W-1:DATA_W] <= strb.data[HI_W-1:0];
    end else if (wideEn && fastTick) begin
      wideQ <= wideQ + FREE_W'(1);
    end
  end

  assign cntOut = cntQ;
  assign irq = pendQ;
  assign wideCnt = wideQ;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NARROW_CNT = 2,
  parameter int NARROW_W = 16,
  parameter int BROAD_W = 32,
  parameter int FREE_W = 40
) (
  input  logic clk,
  input  logic rstN,
  input  logic slowTick,
  input  logic fastTick,
  input  logic wrEn,
  input  logic [3:0] addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic [2:0] irq
);
  strobe_t strb;
  logic [NUM_TMR-1:0] tmrEn;
  logic [NUM_TMR-1:0] tmrPer;
  logic [NUM_TMR-1:0] tmrSlow;
  logic [NUM_TMR-1:0][DATA_W-1:0] loadVal;
  logic [NUM_TMR-1:0][DATA_W-1:0] cntOut;
  logic [FREE_W-1:0] wideCnt;
  logic wideEn;

  tmr_ctrl #(
    .NARROW_CNT(NARROW_CNT), .NARROW_W(NARROW_W), .BROAD_W(BROAD_W), .FREE_W(FREE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .cntOut(cntOut), .wideCnt(wideCnt), .strb(strb), .tmrEn(tmrEn),
    .tmrPer(tmrPer), .tmrSlow(tmrSlow), .loadVal(loadVal), .wideEn(wideEn),
    .rdData(rdData)
  );

  tmr_dpath #(
    .NARROW_CNT(NARROW_CNT), .NARROW_W(NARROW_W), .BROAD_W(BROAD_W), .FREE_W(FREE_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .fastTick(fastTick),
    .strb(strb), .tmrEn(tmrEn), .tmrPer(tmrPer), .tmrSlow(tmrSlow),
    .loadVal(loadVal), .wideEn(wideEn), .cntOut(cntOut), .irq(irq),
    .wideCnt(wideCnt)
  );
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk (
  input logic clk,
  input logic rstN,
  input logic slowTick,
  input logic fastTick,
  input logic wrEn,
  input logic [3:0] addr,
  input logic [2:0] irq,
  input logic [2:0][31:0] cntOut,
  input logic [2:0] tmrEn,
  input logic [39:0] wideCnt,
  input logic wideEn
);
  logic wideWr;
  assign wideWr = wrEn && (addr[3:2] == 2'd3) && !addr[1];

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_prop
      // R3: an interrupt only appears after a tick cycle
      p_irq_after_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
        $rose(irq[g]) |-> $past(slowTick || fastTick));
      // R6: a clear write without competing tick drops the interrupt
      p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && addr == 4'(4*g+3) && !slowTick && !fastTick) |=> !irq[g]);
      // R7: a stopped timer holds its count unless loaded
      p_stop_freeze_r7: assert property (@(posedge clk) disable iff (!rstN)
        (!tmrEn[g] && !(wrEn && addr == 4'(4*g))) |=> $stable(cntOut[g]));
    end
  endgenerate

  // R10: the wide counter moves only on a fast tick or a write
  p_wide_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!fastTick && !wideWr) |=> $stable(wideCnt));

  // R11: a running wide counter steps by exactly one, carrying across the low word
  p_wide_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    (fastTick && wideEn && !wideWr) |=> (wideCnt == $past(wideCnt) + 40'd1));
endmodule

bind tmr_unit tmr_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .slowTick(slowTick), .fastTick(fastTick),
  .wrEn(wrEn), .addr(addr), .irq(irq), .cntOut(cntOut), .tmrEn(tmrEn),
  .wideCnt(wideCnt), .wideEn(wideEn)
);

// File: tb/tmr_unit_bench.sv
`timescale 1ns/1ps
module tmr_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slowTick = 1'b0;
  logic fastTick = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [2:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit isIrq;
    int idx;
    logic [31:0] exp;
    string req;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  tmr_unit u_tmr_unit (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .fastTick(fastTick),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = it.isIrq ? 32'(irq[it.idx]) : rdData;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: %s actual 0x%08h expected 0x%08h", it.req,
                 it.isIrq ? "irq" : "read", act, it.exp);
      end
    end
  end

  task automatic cyc(input bit w, input logic [3:0] a, input logic [31:0] d,
                     input bit s, input bit f);
    @(posedge clk); #1;
    wrEn = w; addr = a; wrData = d; slowTick = s; fastTick = f;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic tickS(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, addr, '0, 1'b1, 1'b0);
  endtask

  task automatic tickF(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, addr, '0, 1'b0, 1'b1);
  endtask

  task automatic chkRd(input logic [3:0] a, input logic [31:0] e, input string req);
    item_t it;
    cyc(1'b0, a, '0, 1'b0, 1'b0);
    it.isIrq = 1'b0; it.idx = 0; it.exp = e; it.req = req;
    sb.push_back(it);
  endtask

  task automatic chkIrq(input int i, input bit e, input string req);
    item_t it;
    cyc(1'b0, addr, '0, 1'b0, 1'b0);
    it.isIrq = 1'b1; it.idx = i; it.exp = 32'(e); it.req = req;
    sb.push_back(it);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    chkRd(4'd1, 32'h0, "R1");
    chkRd(4'd2, 32'h0, "R1");
    chkRd(4'd9, 32'h0, "R1");
    chkRd(4'd12, 32'h0, "R1");
    chkRd(4'd13, 32'h0, "R1");
    chkIrq(0, 1'b0, "R1");

    // R2 load while stopped, width truncation, zero extension
    wr(4'd0, 32'h0001_2345);
    chkRd(4'd0, 32'h0000_2345, "R2");
    chkRd(4'd1, 32'h0000_2345, "R2");
    wr(4'd8, 32'hDEAD_BEEF);
    chkRd(4'd9, 32'hDEAD_BEEF, "R2");

    // R3 periodic with N = 5 on the slow tick
    wr(4'd4, 32'd4);
    chkRd(4'd5, 32'd4, "R2");
    wr(4'd6, 32'hC8);
    tickS(4);
    chkRd(4'd5, 32'd0, "R3");
    chkIrq(1, 1'b0, "R3");
    tickS(1);
    chkRd(4'd5, 32'd4, "R3");
    chkIrq(1, 1'b1, "R3");
    wr(4'd7, 32'h0);
    chkIrq(1, 1'b0, "R6");

    // R5 tick selection
    tickF(3);
    chkRd(4'd5, 32'd4, "R5");
    wr(4'd6, 32'hC0);
    tickS(2);
    chkRd(4'd5, 32'd4, "R5");
    tickF(1);
    chkRd(4'd5, 32'd3, "R5");

    // R7 stop freezes count and keeps pending
    tickF(4);
    chkRd(4'd5, 32'd4, "R3");
    chkIrq(1, 1'b1, "R3");
    wr(4'd6, 32'h40);
    tickF(2);
    tickS(1);
    chkRd(4'd5, 32'd4, "R7");
    chkIrq(1, 1'b1, "R7");

    // R9 control readback
    chkRd(4'd6, 32'h40, "R9");
    wr(4'd6, 32'hFF);
    chkRd(4'd6, 32'hC8, "R9");
    wr(4'd6, 32'h48);
    chkRd(4'd6, 32'h48, "R9");

    // R6 underflow wins over simultaneous clear
    wr(4'd7, 32'h0);
    chkIrq(1, 1'b0, "R6");
    wr(4'd4, 32'd0);
    chkRd(4'd5, 32'd0, "R2");
    wr(4'd6, 32'hC8);
    cyc(1'b1, 4'd7, 32'h0, 1'b1, 1'b0);
    chkIrq(1, 1'b1, "R6");
    chkRd(4'd5, 32'd0, "R6");
    wr(4'd7, 32'h0);
    chkIrq(1, 1'b0, "R6");

    // R8 load while running
    wr(4'd4, 32'd2);
    chkRd(4'd5, 32'd0, "R8");
    chkRd(4'd4, 32'd2, "R8");
    tickS(1);
    chkRd(4'd5, 32'd2, "R8");
    chkIrq(1, 1'b1, "R8");
    wr(4'd6, 32'h48);
    wr(4'd7, 32'h0);

    // R4 free mode wrap
    wr(4'd0, 32'd1);
    wr(4'd2, 32'h88);
    tickS(1);
    chkRd(4'd1, 32'd0, "R4");
    tickS(1);
    chkRd(4'd1, 32'h0000_FFFF, "R4");
    chkIrq(0, 1'b1, "R4");
    wr(4'd2, 32'h08);
    wr(4'd8, 32'd0);
    chkRd(4'd9, 32'd0, "R2");
    wr(4'd10, 32'h88);
    tickS(1);
    chkRd(4'd9, 32'hFFFF_FFFF, "R4");
    chkIrq(2, 1'b1, "R4");
    wr(4'd10, 32'h08);

    // R10 wide counter run flag and tick
    chkRd(4'd12, 32'd0, "R10");
    tickF(1);
    chkRd(4'd12, 32'd0, "R10");
    wr(4'd13, 32'h100);
    chkRd(4'd13, 32'h100, "R10");
    tickF(3);
    chkRd(4'd12, 32'd3, "R10");
    tickS(2);
    chkRd(4'd12, 32'd3, "R10");
    wr(4'd13, 32'h0);
    chkRd(4'd13, 32'h0, "R10");
    tickF(1);
    chkRd(4'd12, 32'd3, "R10");

    // R11 low word wrap and carry
    wr(4'd12, 32'hFFFF_FFFE);
    chkRd(4'd12, 32'hFFFF_FFFE, "R11");
    wr(4'd13, 32'h105);
    tickF(1);
    chkRd(4'd12, 32'hFFFF_FFFF, "R11");
    tickF(1);
    chkRd(4'd12, 32'h0, "R11");
    chkRd(4'd13, 32'h106, "R11");

    // R12 unmapped and clear words read zero
    chkRd(4'd14, 32'h0, "R12");
    chkRd(4'd15, 32'h0, "R12");
    chkRd(4'd3, 32'h0, "R12");

    cyc(1'b0, 4'd0, '0, 1'b0, 1'b0);
    @(negedge clk);
    #1;
    done = 1'b1;
    finishRun();
  end
endmodule